// File: doc/BRIEF.md
# Frame Admission Buffer

This block sits behind a packet receive path and takes a stream of 32-bit words carrying data frames. Each frame opens with a four-word header, marked by a start-of-frame strobe on its first word. The block reads the header and checks the frame length, station and band fields against ranges held on configuration inputs. It also checks an invalid flag in the header. A frame that passes is written into one of two on-chip frame slots. A frame that fails is still consumed word by word, so the next header lines up. Four counters record frames that were accepted, rejected for range, rejected as invalid, and lost to overrun.

Each slot has a validity bit. The bit goes high once every payload word of an accepted frame has been stored. Nothing is read out until a processing-period tick arrives. The tick starts one pass over both slots in fixed order. A filled slot sends out its payload with the frame-good flag high and clears its validity bit. An empty slot sends a single placeholder word with the flag low. Downstream logic can therefore tell which slots carried data in that period.

Top module: `frame_admit_buf`

## Requirements
- R1: An accepted frame sets its slot's bit in `slot_valid` on the clock edge that stores its last payload word, and `cnt_accept` rises by one on that same edge. After reset, `slot_valid`, `out_valid` and all four counters are zero.
- R2: A frame whose header word 0 has bit 31 set is discarded even if every field is in range, and `cnt_invalid` rises by one.
- R3: A frame whose length, station or band lies outside the inclusive configured range is discarded, and `cnt_range` rises by one. A length below 3 or above SLOT_WORDS/2+2 is also treated as out of range.
- R4: Header word 2 bits 23:0 hold the frame length L in 8-byte units, counting the 16-byte header. The payload is therefore 2L-4 words. Header word 3 bits 15:0 hold the station and bits 25:16 hold the band.
- R5: A frame that passes the checks while both slots are valid is discarded, and `cnt_overrun` rises by one.
- R6: A start-of-frame strobe that arrives while a payload is still being stored abandons that slot, leaving its bit low. The new frame is discarded up to the next strobe, and `cnt_overrun` rises by one.
- R7: Readout starts only on `in_tick`. The first output word appears one clock after the edge that samples the tick.
- R8: A readout pass visits slot 0 and then slot 1. A valid slot sends its payload words in arrival order with `out_frame_ok` high and `out_eof` on the last word. An empty slot sends one word with `out_frame_ok` low and `out_eof` high.
- R9: A slot's validity bit falls at the same edge that presents that slot's `out_eof` word.
- R10: A tick that arrives during a readout pass is ignored; no second pass follows.
- R11: The payload of a discarded frame is consumed, so the next frame's header is decoded correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_sof | input | 1 | Marks header word 0 |
| in_data | input | 32 | Input word |
| in_tick | input | 1 | Processing-period tick |
| cfg_len_lo | input | 24 | Lowest accepted length |
| cfg_len_hi | input | 24 | Highest accepted length |
| cfg_sta_lo | input | 16 | Lowest accepted station |
| cfg_sta_hi | input | 16 | Highest accepted station |
| cfg_band_lo | input | 10 | Lowest accepted band |
| cfg_band_hi | input | 10 | Highest accepted band |
| out_valid | output | 1 | Output word present |
| out_data | output | 32 | Output word (don't-care on placeholder) |
| out_eof | output | 1 | Last word of a slot |
| out_frame_ok | output | 1 | Slot validity during readout |
| slot_valid | output | 2 | Per-slot validity bits |
| cnt_accept | output | CNT_W | Accepted frames |
| cnt_range | output | CNT_W | Range rejects |
| cnt_invalid | output | CNT_W | Invalid-flag rejects |
| cnt_overrun | output | CNT_W | Overrun drops |

## Verification
Admission results are due on the edge that samples the last payload word, or the fourth header word for a rejected frame. The bench drives words on falling edges and reads `slot_valid` and the counters at the falling edge after its final word, once that edge has passed. Readout is checked for timing as well as content: `out_valid` must still be low half a cycle after the tick edge and high one cycle later. A monitor records every output word on falling edges. Word counts are compared only after a settling window, which also shows that a tick sent mid-pass caused no second pass.

// File: rtl/fab_pkg.sv
package fab_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 24;
  localparam int STA_W  = 16;
  localparam int BAND_W = 10;
  localparam int MIN_LEN = 3;

  typedef enum logic [1:0] {W_IDLE, W_HDR, W_PAY, W_SKIP} wr_state_t;
  typedef enum logic {R_IDLE, R_RUN} rd_state_t;
endpackage

// File: rtl/fab_hdr_check.sv
module fab_hdr_check
  import fab_pkg::*;
#(
  parameter int SLOT_WORDS = 64
) (
  input  logic [LEN_W-1:0]  len,
  input  logic [STA_W-1:0]  sta,
  input  logic [BAND_W-1:0] band,
  input  logic [LEN_W-1:0]  len_lo,
  input  logic [LEN_W-1:0]  len_hi,
  input  logic [STA_W-1:0]  sta_lo,
  input  logic [STA_W-1:0]  sta_hi,
  input  logic [BAND_W-1:0] band_lo,
  input  logic [BAND_W-1:0] band_hi,
  output logic              fields_ok
);
  localparam int MAX_LEN = SLOT_WORDS / 2 + 2;

  logic len_ok, sta_ok, band_ok, len_fits;

  always_comb begin
    len_fits  = (len >= LEN_W'(MIN_LEN)) && (len <= LEN_W'(MAX_LEN));
    len_ok    = (len >= len_lo) && (len <= len_hi);
    sta_ok    = (sta >= sta_lo) && (sta <= sta_hi);
    band_ok   = (band >= band_lo) && (band <= band_hi);
    fields_ok = len_fits && len_ok && sta_ok && band_ok;
  end
endmodule

// File: rtl/fab_slot_ram.sv
module fab_slot_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    if (re) q <= mem[ra];
  end
endmodule

// File: rtl/fab_writer.sv
module fab_writer
  import fab_pkg::*;
#(
  parameter int SLOT_WORDS = 64,
  localparam int SW_LOG = $clog2(SLOT_WORDS),
  localparam int IW     = SW_LOG + 1,
  localparam int AW     = SW_LOG + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic [WORD_W-1:0] in_data,
  input  logic [LEN_W-1:0]  len_lo,
  input  logic [LEN_W-1:0]  len_hi,
  input  logic [STA_W-1:0]  sta_lo,
  input  logic [STA_W-1:0]  sta_hi,
  input  logic [BAND_W-1:0] band_lo,
  input  logic [BAND_W-1:0] band_hi,
  input  logic [1:0]        slot_busy,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              done,
  output logic              done_slot,
  output logic [IW-1:0]     done_len,
  output logic              ev_inv,
  output logic              ev_rng,
  output logic              ev_ovr
);
  wr_state_t        st_q;
  logic [1:0]       hcnt_q;
  logic             inv_q;
  logic [LEN_W-1:0] len_q;
  logic             slot_q;
  logic [IW-1:0]    widx_q;
  logic [IW-1:0]    plen_q;

  logic          fields_ok, decide, no_free, free_slot, last_w;
  logic [IW-1:0] plen_n;

  fab_hdr_check #(.SLOT_WORDS(SLOT_WORDS)) u_chk (
    .len(len_q), .sta(in_data[15:0]), .band(in_data[25:16]),
    .len_lo(len_lo), .len_hi(len_hi), .sta_lo(sta_lo), .sta_hi(sta_hi),
    .band_lo(band_lo), .band_hi(band_hi), .fields_ok(fields_ok)
  );

  always_comb begin
    no_free   = &slot_busy;
    free_slot = slot_busy[0];
    plen_n    = IW'({len_q, 1'b0} - (LEN_W+1)'(4));
    decide    = in_valid && !in_sof && (st_q == W_HDR) && (hcnt_q == 2'd3);
    wr_en     = in_valid && !in_sof && (st_q == W_PAY);
    wr_addr   = {slot_q, widx_q[SW_LOG-1:0]};
    wr_data   = in_data;
    last_w    = (widx_q == plen_q - 1'b1);
    done      = wr_en && last_w;
    done_slot = slot_q;
    done_len  = plen_q;
    ev_inv    = decide && inv_q;
    ev_rng    = decide && !inv_q && !fields_ok;
    ev_ovr    = (in_valid && in_sof && (st_q == W_PAY)) ||
                (decide && !inv_q && fields_ok && no_free);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= W_IDLE;
      hcnt_q <= '0;
      inv_q  <= 1'b0;
      len_q  <= '0;
      slot_q <= 1'b0;
      widx_q <= '0;
      plen_q <= '0;
    end else if (in_valid) begin
      if (in_sof) begin
        if (st_q == W_PAY) begin
          st_q <= W_SKIP;
        end else begin
          st_q   <= W_HDR;
          hcnt_q <= 2'd1;
          inv_q  <= in_data[31];
        end
      end else begin
        case (st_q)
          W_HDR: begin
            if (hcnt_q == 2'd3) begin
              if (inv_q || !fields_ok || no_free) begin
                st_q <= W_SKIP;
              end else begin
                st_q   <= W_PAY;
                slot_q <= free_slot;
                widx_q <= '0;
                plen_q <= plen_n;
              end
            end else begin
              if (hcnt_q == 2'd2) len_q <= in_data[LEN_W-1:0];
              hcnt_q <= hcnt_q + 2'd1;
            end
          end
          W_PAY: begin
            widx_q <= widx_q + 1'b1;
            if (last_w) st_q <= W_IDLE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/fab_reader.sv
module fab_reader
  import fab_pkg::*;
#(
  parameter int SLOT_WORDS = 64,
  localparam int SW_LOG = $clog2(SLOT_WORDS),
  localparam int IW     = SW_LOG + 1,
  localparam int AW     = SW_LOG + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic [1:0]         slot_ok,
  input  logic [1:0][IW-1:0] slot_len,
  output logic               rd_en,
  output logic [AW-1:0]      rd_addr,
  output logic [1:0]         clr,
  output logic               o_valid,
  output logic               o_eof,
  output logic               o_ok
);
  rd_state_t     st_q;
  logic          rslot_q;
  logic [IW-1:0] ridx_q;

  logic          run, cur_ok, last;
  logic [IW-1:0] cur_len;

  always_comb begin
    run     = (st_q == R_RUN);
    cur_ok  = slot_ok[rslot_q];
    cur_len = slot_len[rslot_q];
    last    = !cur_ok || (ridx_q == cur_len - 1'b1);
    rd_en   = run;
    rd_addr = {rslot_q, ridx_q[SW_LOG-1:0]};
    clr     = '0;
    if (run && last && cur_ok) clr[rslot_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= R_IDLE;
      rslot_q <= 1'b0;
      ridx_q  <= '0;
      o_valid <= 1'b0;
      o_eof   <= 1'b0;
      o_ok    <= 1'b0;
    end else begin
      o_valid <= run;
      o_eof   <= run && last;
      o_ok    <= run && cur_ok;
      if (!run) begin
        if (tick) begin
          st_q    <= R_RUN;
          rslot_q <= 1'b0;
          ridx_q  <= '0;
        end
      end else if (last) begin
        ridx_q <= '0;
        if (rslot_q) st_q <= R_IDLE;
        rslot_q <= ~rslot_q;
      end else begin
        ridx_q <= ridx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/frame_admit_buf.sv
module frame_admit_buf
  import fab_pkg::*;
#(
  parameter int SLOT_WORDS = 64,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic [31:0]       in_data,
  input  logic              in_tick,
  input  logic [23:0]       cfg_len_lo,
  input  logic [23:0]       cfg_len_hi,
  input  logic [15:0]       cfg_sta_lo,
  input  logic [15:0]       cfg_sta_hi,
  input  logic [9:0]        cfg_band_lo,
  input  logic [9:0]        cfg_band_hi,
  output logic              out_valid,
  output logic [31:0]       out_data,
  output logic              out_eof,
  output logic              out_frame_ok,
  output logic [1:0]        slot_valid,
  output logic [CNT_W-1:0]  cnt_accept,
  output logic [CNT_W-1:0]  cnt_range,
  output logic [CNT_W-1:0]  cnt_invalid,
  output logic [CNT_W-1:0]  cnt_overrun
);
  localparam int SW_LOG = $clog2(SLOT_WORDS);
  localparam int IW     = SW_LOG + 1;
  localparam int AW     = SW_LOG + 1;
  localparam int DEPTH  = 2 * SLOT_WORDS;
  localparam int N_EV   = 4;

  logic              wr_en, done, done_slot, ev_inv, ev_rng, ev_ovr;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic [WORD_W-1:0] wr_data;
  logic [IW-1:0]     done_len;
  logic              rd_en;
  logic [1:0]        clr, set_v;
  logic [1:0]        valid_q;
  logic [1:0][IW-1:0] len_q;
  logic [N_EV-1:0]   ev;
  logic [CNT_W-1:0]  cnt [N_EV];

  fab_writer #(.SLOT_WORDS(SLOT_WORDS)) u_wr (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
    .len_lo(cfg_len_lo), .len_hi(cfg_len_hi), .sta_lo(cfg_sta_lo), .sta_hi(cfg_sta_hi),
    .band_lo(cfg_band_lo), .band_hi(cfg_band_hi), .slot_busy(valid_q),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done),
    .done_slot(done_slot), .done_len(done_len),
    .ev_inv(ev_inv), .ev_rng(ev_rng), .ev_ovr(ev_ovr)
  );

  fab_slot_ram #(.DW(WORD_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(wr_en), .wa(wr_addr), .wd(wr_data),
    .re(rd_en), .ra(rd_addr), .q(out_data)
  );

  fab_reader #(.SLOT_WORDS(SLOT_WORDS)) u_rd (
    .clk(clk), .rst(rst), .tick(in_tick), .slot_ok(valid_q), .slot_len(len_q),
    .rd_en(rd_en), .rd_addr(rd_addr), .clr(clr),
    .o_valid(out_valid), .o_eof(out_eof), .o_ok(out_frame_ok)
  );

  always_comb begin
    set_v = '0;
    if (done) set_v[done_slot] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      len_q   <= '0;
    end else begin
      valid_q <= (valid_q & ~clr) | set_v;
      if (done) len_q[done_slot] <= done_len;
    end
  end

  assign ev = {ev_ovr, ev_inv, ev_rng, done};

  for (genvar g = 0; g < N_EV; g++) begin : g_cnt
    logic [CNT_W-1:0] c_q;
    always_ff @(posedge clk) begin
      if (rst)        c_q <= '0;
      else if (ev[g]) c_q <= c_q + 1'b1;
    end
    assign cnt[g] = c_q;
  end

  assign slot_valid  = valid_q;
  assign cnt_accept  = cnt[0];
  assign cnt_range   = cnt[1];
  assign cnt_invalid = cnt[2];
  assign cnt_overrun = cnt[3];
endmodule

// File: rtl/frame_admit_buf_chk.sv
module frame_admit_buf_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_tick,
  input logic             out_valid,
  input logic             out_eof,
  input logic             out_frame_ok,
  input logic [1:0]       slot_valid,
  input logic [CNT_W-1:0] cnt_accept,
  input logic [CNT_W-1:0] cnt_overrun
);
  // R7
  tick_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_tick, 2));

  // R8
  empty_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_frame_ok) |-> out_eof);

  // R8
  eof_framing_chk: assert property (@(posedge clk) disable iff (rst)
    out_eof |-> out_valid);

  // R9
  clr0_eof_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(slot_valid[0]) |-> (out_valid && out_eof && out_frame_ok));

  // R9
  clr1_eof_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(slot_valid[1]) |-> (out_valid && out_eof && out_frame_ok));

  // R1
  accept_step_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(slot_valid[0]) || $rose(slot_valid[1])) |-> (cnt_accept == CNT_W'($past(cnt_accept) + 1'b1)));

  // R5
  overrun_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cnt_overrun) |-> (cnt_overrun == CNT_W'($past(cnt_overrun) + 1'b1)));
endmodule

bind frame_admit_buf frame_admit_buf_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .in_tick(in_tick), .out_valid(out_valid), .out_eof(out_eof),
  .out_frame_ok(out_frame_ok), .slot_valid(slot_valid),
  .cnt_accept(cnt_accept), .cnt_overrun(cnt_overrun)
);

// File: tb/frame_admit_buf_tb_top.sv
module frame_admit_buf_tb_top;
  localparam int SW = 64;
  localparam int CW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, in_valid, in_sof, in_tick;
  logic [31:0] in_data;
  logic out_valid, out_eof, out_frame_ok;
  logic [31:0] out_data;
  logic [1:0] slot_valid;
  logic [CW-1:0] cnt_accept, cnt_range, cnt_invalid, cnt_overrun;

  frame_admit_buf #(.SLOT_WORDS(SW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
    .in_tick(in_tick), .cfg_len_lo(24'd3), .cfg_len_hi(24'd20),
    .cfg_sta_lo(16'd10), .cfg_sta_hi(16'd13), .cfg_band_lo(10'd0), .cfg_band_hi(10'd3),
    .out_valid(out_valid), .out_data(out_data), .out_eof(out_eof),
    .out_frame_ok(out_frame_ok), .slot_valid(slot_valid),
    .cnt_accept(cnt_accept), .cnt_range(cnt_range),
    .cnt_invalid(cnt_invalid), .cnt_overrun(cnt_overrun)
  );

  int n_chk = 0, n_err = 0;
  int n_out = 0;
  int rd_mark = 0;
  logic [31:0] m_data [512];
  logic        m_eof  [512];
  logic        m_ok   [512];

  always @(negedge clk) begin
    if (out_valid && n_out < 512) begin
      m_data[n_out] = out_data;
      m_eof[n_out]  = out_eof;
      m_ok[n_out]   = out_frame_ok;
      n_out = n_out + 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pay(input int base, input int i);
    return 32'(base * 256 + i);
  endfunction

  task automatic send_frame(input bit inv, input int len, input int sta, input int band,
                            input int npay, input int base);
    @(negedge clk);
    in_valid = 1'b1; in_sof = 1'b1; in_data = {inv, 31'd0};
    @(negedge clk);
    in_sof = 1'b0; in_data = 32'h1234_0000;
    @(negedge clk);
    in_data = {8'd0, 24'(len)};
    @(negedge clk);
    in_data = {6'd0, 10'(band), 16'(sta)};
    for (int i = 0; i < npay; i++) begin
      @(negedge clk);
      in_data = pay(base, i);
    end
    @(negedge clk);
    in_valid = 1'b0; in_data = '0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); in_tick = 1'b1;
    @(negedge clk); in_tick = 1'b0;
  endtask

  task automatic read_pass(input int exp_n, input string req);
    rd_mark = n_out;
    pulse_tick();
    repeat (exp_n + 8) @(negedge clk);
    chk(req, "words in pass", n_out - rd_mark, exp_n);
  endtask

  task automatic chk_word(input string req, input int k, input bit use_data,
                          input logic [31:0] d, input bit ok, input bit eof);
    int idx = rd_mark + k;
    if (use_data) chk(req, $sformatf("word %0d data", k), int'(m_data[idx]), int'(d));
    chk(req, $sformatf("word %0d ok", k), int'(m_ok[idx]), int'(ok));
    chk(req, $sformatf("word %0d eof", k), int'(m_eof[idx]), int'(eof));
  endtask

  task automatic t_reset();
    chk("R1", "reset slot_valid", int'(slot_valid), 0);
    chk("R1", "reset out_valid", int'(out_valid), 0);
    chk("R1", "reset cnt_accept", int'(cnt_accept), 0);
    chk("R1", "reset other counters", int'(cnt_range) + int'(cnt_invalid) + int'(cnt_overrun), 0);
  endtask

  task automatic t_accept();
    send_frame(1'b0, 5, 10, 2, 6, 1);
    chk("R1", "slot_valid after accept", int'(slot_valid), 1);
    chk("R1", "cnt_accept after accept", int'(cnt_accept), 1);
  endtask

  task automatic t_invalid();
    send_frame(1'b1, 5, 11, 1, 6, 9);
    chk("R2", "slot_valid after invalid", int'(slot_valid), 1);
    chk("R2", "cnt_invalid", int'(cnt_invalid), 1);
    chk("R2", "cnt_accept unchanged", int'(cnt_accept), 1);
  endtask

  task automatic t_range();
    send_frame(1'b0, 5, 14, 1, 6, 9);
    send_frame(1'b0, 5, 12, 4, 6, 9);
    send_frame(1'b0, 21, 12, 1, 38, 9);
    send_frame(1'b0, 2, 12, 1, 0, 9);
    chk("R3", "cnt_range", int'(cnt_range), 4);
    chk("R3", "slot_valid after range rejects", int'(slot_valid), 1);
    // R11 and R4: boundary length 3 right after rejects
    send_frame(1'b0, 3, 13, 0, 2, 2);
    chk("R11", "slot_valid after rejects then good", int'(slot_valid), 3);
    chk("R11", "cnt_accept", int'(cnt_accept), 2);
  endtask

  task automatic t_no_tick();
    int m = n_out;
    repeat (20) @(negedge clk);
    chk("R7", "no output without tick", n_out - m, 0);
  endtask

  task automatic t_readout();
    rd_mark = n_out;
    @(negedge clk); in_tick = 1'b1;
    @(negedge clk); in_tick = 1'b0;
    chk("R7", "out_valid half cycle after tick edge", int'(out_valid), 0);
    @(negedge clk);
    chk("R7", "out_valid one cycle later", int'(out_valid), 1);
    // R10: second tick during the pass
    in_tick = 1'b1;
    @(negedge clk); in_tick = 1'b0;
    repeat (30) @(negedge clk);
    chk("R4", "words in pass", n_out - rd_mark, 8);
    for (int i = 0; i < 6; i++) chk_word("R8", i, 1'b1, pay(1, i), 1'b1, i == 5);
    for (int i = 0; i < 2; i++) chk_word("R8", 6 + i, 1'b1, pay(2, i), 1'b1, i == 1);
    chk("R9", "slot_valid after pass", int'(slot_valid), 0);
    chk("R10", "no extra pass", n_out - rd_mark, 8);
  endtask

  task automatic t_empty();
    read_pass(2, "R8");
    chk_word("R8", 0, 1'b0, '0, 1'b0, 1'b1);
    chk_word("R8", 1, 1'b0, '0, 1'b0, 1'b1);
  endtask

  task automatic t_overrun();
    send_frame(1'b0, 4, 10, 0, 4, 3);
    send_frame(1'b0, 4, 10, 0, 4, 4);
    send_frame(1'b0, 4, 10, 0, 4, 5);
    chk("R5", "slot_valid both full", int'(slot_valid), 3);
    chk("R5", "cnt_overrun", int'(cnt_overrun), 1);
    chk("R5", "cnt_accept", int'(cnt_accept), 4);
    read_pass(8, "R5");
    for (int i = 0; i < 4; i++) chk_word("R5", i, 1'b1, pay(3, i), 1'b1, i == 3);
    for (int i = 0; i < 4; i++) chk_word("R5", 4 + i, 1'b1, pay(4, i), 1'b1, i == 3);
  endtask

  task automatic t_abort();
    send_frame(1'b0, 6, 10, 0, 3, 6);
    send_frame(1'b0, 4, 10, 0, 4, 7);
    chk("R6", "slot_valid after abort", int'(slot_valid), 0);
    chk("R6", "cnt_overrun", int'(cnt_overrun), 2);
    chk("R6", "cnt_accept unchanged", int'(cnt_accept), 4);
    send_frame(1'b0, 4, 10, 0, 4, 8);
    chk("R6", "slot_valid after recovery", int'(slot_valid), 1);
    read_pass(5, "R6");
    for (int i = 0; i < 4; i++) chk_word("R6", i, 1'b1, pay(8, i), 1'b1, i == 3);
    chk_word("R6", 4, 1'b0, '0, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_sof = 1'b0; in_tick = 1'b0; in_data = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_accept();
    t_invalid();
    t_range();
    t_no_tick();
    t_readout();
    t_empty();
    t_overrun();
    t_abort();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule